// File: doc/BRIEF.md
# Multi-Mode Serial Line Decoder

This block turns a received serial line back into data bits. The line can carry one of four line codes, chosen by a 2-bit code select: plain level coding (NRZ), transition coding (NRZI), and the two biphase codes, biphase mark (FM1) and biphase space (FM0). A separate Manchester (biphase level) enable handles Manchester as a biphase-type input whose output polarity follows NRZ.

Two inputs come from outside the block: a line level that is already synchronized, and two sample strobes from a clock-recovery stage. The boundary strobe samples the first half of a bit cell. The mid strobe samples the second half.

- NRZ and NRZI use only the mid sample, which gives one sample per cell.
- The biphase codes compare the two half-cell levels, and also compare the first half with the level that ended the previous cell.

Each recovered bit leaves the block together with a one-cycle valid pulse. A code-violation flag goes with that pulse when a biphase cell has no transition at its boundary.

Top module: `serdec_line_decoder`

## Requirements
- R1: With Manchester off and `code_sel_i` = 2'b00 (NRZ), the decoded bit equals the line level sampled at the mid strobe. The boundary strobe has no effect in this code.
- R2: With `code_sel_i` = 2'b01 (NRZI), the decoded bit is 1 when the mid sample equals the previous cell's mid sample, and 0 when it differs.
- R3: With `code_sel_i` = 2'b10 (FM1), the decoded bit is 1 when the first-half level (taken at the boundary strobe) differs from the second-half level (taken at the mid strobe), and 0 when they are equal.
- R4: With `code_sel_i` = 2'b11 (FM0), the decoded bit is 1 when the two half-cell levels are equal, and 0 when they differ.
- R5: With `manch_en_i` = 1, `code_sel_i` is ignored. A high-to-low mid-cell change decodes as 1 and a low-to-high change decodes as 0, so the bit equals the first-half level. No code violation is ever flagged in this mode.
- R6: In FM1 or FM0, a cell whose first-half level equals the previous cell's second-half level raises `code_err_o` together with that cell's valid pulse. In NRZ and NRZI, `code_err_o` stays 0.
- R7: `bit_vld_o` is high for exactly one clock, in the cycle after the clock edge that samples the mid strobe. `bit_o` and `code_err_o` are valid in that same cycle. No valid pulse is produced without a mid strobe.
- R8: Reset drives `bit_vld_o`, `bit_o` and `code_err_o` low and sets the stored previous-cell level to low. That level is then used by the first NRZI cell and by the first biphase boundary check.
- R9: In the biphase codes and in Manchester, a mid strobe that has no boundary strobe earlier in the same cell produces no valid pulse.
- R10: The stored previous-cell level is updated only by mid strobes, in every code. A boundary strobe never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_sel_i | input | 2 | Line code: 00 NRZ, 01 NRZI, 10 FM1, 11 FM0 |
| manch_en_i | input | 1 | Manchester decoding; overrides code_sel_i |
| line_i | input | 1 | Synchronized receive line level |
| bnd_stb_i | input | 1 | Strobe sampling the first half of a cell |
| mid_stb_i | input | 1 | Strobe sampling the second half of a cell |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-cycle pulse marking a new decoded bit |
| code_err_o | output | 1 | Missing boundary transition in a biphase cell |

## Verification
Only two bits of state carry forward across cells, so faults in either show up at the ports within one cell.

- The stored previous level: if it is wrong, the next NRZI bit inverts, or the next biphase cell gains or loses its code-violation flag. Both appear on the next valid pulse.
- The half-cell flag: if it is stuck set, a lone mid strobe in a biphase code produces a pulse that should not exist. If it is stuck clear, every biphase bit is lost.

The stimulus steps through cell sequences in which each of these faults changes a result compared against an independent expectation.

// File: rtl/serdec_pkg.sv
package serdec_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        LC_NRZ  = 2'b00,
        LC_NRZI = 2'b01,
        LC_FM1  = 2'b10,
        LC_FM0  = 2'b11
    } line_code_e;

    // State carried between the two halves of a cell and across cells
    typedef struct packed {
        logic first_seen;
        logic first_lvl;
        logic prev_lvl;
    } half_state_t;

    // Registered outputs
    typedef struct packed {
        logic vld;
        logic bit_val;
        logic err;
    } out_state_t;

endpackage

// File: rtl/serdec_half_capture.sv
module serdec_half_capture
    import serdec_pkg::*;
#(
    parameter logic PREV_INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic bnd_stb_i,
    input  logic mid_stb_i,
    output logic first_seen_o,
    output logic first_lvl_o,
    output logic prev_lvl_o
);

    half_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bnd_stb_i) begin
            st_d.first_seen = 1'b1;
            st_d.first_lvl  = line_i;
        end
        if (mid_stb_i) begin
            st_d.first_seen = 1'b0;
            st_d.prev_lvl   = line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.first_seen <= 1'b0;
            st_q.first_lvl  <= 1'b0;
            st_q.prev_lvl   <= PREV_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign first_seen_o = st_q.first_seen;
    assign first_lvl_o  = st_q.first_lvl;
    assign prev_lvl_o   = st_q.prev_lvl;

    // R10: only a mid strobe moves the stored previous level
    assert_prev_follows_mid_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb_i |=> (prev_lvl_o == $past(line_i)));

    assert_prev_held_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !mid_stb_i |=> $stable(prev_lvl_o));

endmodule

// File: rtl/serdec_cell_logic.sv
module serdec_cell_logic
    import serdec_pkg::*;
(
    input  line_code_e code_i,
    input  logic       manch_i,
    input  logic       first_seen_i,
    input  logic       first_lvl_i,
    input  logic       second_lvl_i,
    input  logic       prev_lvl_i,
    output logic       cell_ok_o,
    output logic       bit_o,
    output logic       err_o
);

    logic halves_differ;
    logic no_boundary_edge;

    assign halves_differ    = first_lvl_i ^ second_lvl_i;
    assign no_boundary_edge = (first_lvl_i == prev_lvl_i);

    always_comb begin
        cell_ok_o = 1'b0;
        bit_o     = 1'b0;
        err_o     = 1'b0;
        if (manch_i) begin
            cell_ok_o = first_seen_i;
            bit_o     = first_lvl_i;
        end else begin
            unique case (code_i)
                LC_NRZ: begin
                    cell_ok_o = 1'b1;
                    bit_o     = second_lvl_i;
                end
                LC_NRZI: begin
                    cell_ok_o = 1'b1;
                    bit_o     = (second_lvl_i == prev_lvl_i);
                end
                LC_FM1: begin
                    cell_ok_o = first_seen_i;
                    bit_o     = halves_differ;
                    err_o     = no_boundary_edge;
                end
                LC_FM0: begin
                    cell_ok_o = first_seen_i;
                    bit_o     = ~halves_differ;
                    err_o     = no_boundary_edge;
                end
                default: begin
                    cell_ok_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/serdec_out_stage.sv
module serdec_out_stage
    import serdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mid_stb_i,
    input  logic cell_ok_i,
    input  logic bit_i,
    input  logic err_i,
    output logic bit_o,
    output logic vld_o,
    output logic err_o
);

    out_state_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = mid_stb_i & cell_ok_i;
        out_d.err = mid_stb_i & cell_ok_i & err_i;
        if (mid_stb_i && cell_ok_i) begin
            out_d.bit_val = bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bit_o = out_q.bit_val;
    assign vld_o = out_q.vld;
    assign err_o = out_q.err;

    // R7: bit value only moves together with a valid pulse
    assert_bit_moves_with_vld_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> $stable(bit_o));

endmodule

// File: rtl/serdec_line_decoder.sv
module serdec_line_decoder
    import serdec_pkg::*;
#(
    parameter logic PREV_INIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_sel_i,
    input  logic       manch_en_i,
    input  logic       line_i,
    input  logic       bnd_stb_i,
    input  logic       mid_stb_i,
    output logic       bit_o,
    output logic       bit_vld_o,
    output logic       code_err_o
);

    line_code_e code;
    logic first_seen, first_lvl, prev_lvl;
    logic cell_ok, cell_bit, cell_err;

    assign code = line_code_e'(code_sel_i);

    serdec_half_capture #(
        .PREV_INIT (PREV_INIT)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .bnd_stb_i    (bnd_stb_i),
        .mid_stb_i    (mid_stb_i),
        .first_seen_o (first_seen),
        .first_lvl_o  (first_lvl),
        .prev_lvl_o   (prev_lvl)
    );

    serdec_cell_logic u_logic (
        .code_i       (code),
        .manch_i      (manch_en_i),
        .first_seen_i (first_seen),
        .first_lvl_i  (first_lvl),
        .second_lvl_i (line_i),
        .prev_lvl_i   (prev_lvl),
        .cell_ok_o    (cell_ok),
        .bit_o        (cell_bit),
        .err_o        (cell_err)
    );

    serdec_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mid_stb_i (mid_stb_i),
        .cell_ok_i (cell_ok),
        .bit_i     (cell_bit),
        .err_i     (cell_err),
        .bit_o     (bit_o),
        .vld_o     (bit_vld_o),
        .err_o     (code_err_o)
    );

    // R7: a valid pulse always follows a mid strobe by one clock
    assert_vld_after_mid_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> $past(mid_stb_i));

    // R9: biphase mid strobe with no first half yields no bit
    assert_no_half_cell_bit_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (mid_stb_i && !first_seen && (manch_en_i || code_sel_i[1])) |=> !bit_vld_o);

    // R5: Manchester never reports a violation
    assert_manch_no_err_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_o && $past(manch_en_i)) |-> !code_err_o);

    // R6: violations only come from FM codes and only with a valid pulse
    assert_err_only_fm_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        code_err_o |-> (bit_vld_o && $past(code_sel_i[1]) && !$past(manch_en_i)));

endmodule

// File: tb/serdec_line_decoder_tb.sv
module serdec_line_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       manch = 1'b0;
    logic       line = 1'b0;
    logic       bnd = 1'b0;
    logic       mid = 1'b0;
    logic       bit_o, vld_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    serdec_line_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_sel_i (code_sel),
        .manch_en_i (manch),
        .line_i     (line),
        .bnd_stb_i  (bnd),
        .mid_stb_i  (mid),
        .bit_o      (bit_o),
        .bit_vld_o  (vld_o),
        .code_err_o (err_o)
    );

    // {manch, code[1:0], first_half, second_half, exp_bit, exp_err}
    localparam int NV = 15;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_00_01_1_0, // R1 NRZ high
        7'b0_00_10_0_0, // R1 NRZ low, first half ignored
        7'b0_01_00_1_0, // R2 NRZI same
        7'b0_01_01_0_0, // R2 NRZI change
        7'b0_01_11_1_0, // R2 NRZI same high
        7'b0_10_01_1_0, // R3 FM1 mid change
        7'b0_10_00_0_0, // R3 FM1 no mid change
        7'b0_11_11_1_0, // R4 FM0 no mid change
        7'b0_11_01_0_0, // R4 FM0 mid change
        7'b0_11_10_0_1, // R6 FM0 missing boundary edge
        7'b0_10_01_1_1, // R6 FM1 missing boundary edge
        7'b1_00_10_1_0, // R5 Manchester high-to-low
        7'b1_11_01_0_0, // R5 Manchester low-to-high, no err
        7'b1_10_11_1_0, // R5 Manchester flat cell, bit = first half
        7'b0_00_01_1_0  // R1 NRZ again
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic send_cell(input logic use_bnd, input logic a, input logic b);
        if (use_bnd) begin
            @(negedge clk); line = a; bnd = 1'b1;
            @(negedge clk); bnd = 1'b0;
        end
        @(negedge clk); line = b; mid = 1'b1;
        @(negedge clk); mid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        #5;
        check("R8 vld in reset", vld_o, 1'b0);
        check("R8 bit in reset", bit_o, 1'b0);
        check("R8 err in reset", err_o, 1'b0);
        do_reset();
        check("R8 vld after reset", vld_o, 1'b0);

        for (int i = 0; i < NV; i++) begin
            manch    = VEC[i][6];
            code_sel = VEC[i][5:4];
            send_cell(1'b1, VEC[i][3], VEC[i][2]);
            check("R7 vld pulse", vld_o, 1'b1);
            check($sformatf("R1-5 bit vec %0d", i), bit_o, VEC[i][1]);
            check($sformatf("R6 err vec %0d", i), err_o, VEC[i][0]);
            @(negedge clk);
            check("R7 vld one cycle", vld_o, 1'b0);
        end

        // R9: biphase lone mid strobe gives no bit
        manch = 1'b0; code_sel = 2'b10;
        send_cell(1'b0, 1'b0, 1'b1);
        check("R9 FM1 lone mid", vld_o, 1'b0);
        manch = 1'b1;
        send_cell(1'b0, 1'b0, 1'b0);
        check("R9 Manchester lone mid", vld_o, 1'b0);

        // R7: boundary strobe alone gives no bit
        manch = 1'b0; code_sel = 2'b11;
        @(negedge clk); line = 1'b1; bnd = 1'b1;
        @(negedge clk); bnd = 1'b0;
        check("R7 no vld on boundary", vld_o, 1'b0);

        // R8 + R10: after reset prev is low; a boundary strobe in NRZI must not move it
        do_reset();
        code_sel = 2'b01;
        send_cell(1'b1, 1'b1, 1'b0);
        check("R10 NRZI vld", vld_o, 1'b1);
        check("R8 R10 NRZI first cell vs low prev", bit_o, 1'b1);

        // R8: first FM1 cell after reset compares with low prev
        do_reset();
        code_sel = 2'b10;
        send_cell(1'b1, 1'b0, 1'b1);
        check("R8 FM1 first bit", bit_o, 1'b1);
        check("R8 R6 FM1 first err", err_o, 1'b1);

        // R6: NRZ never flags, even with equal boundary levels
        code_sel = 2'b00;
        send_cell(1'b1, 1'b1, 1'b1);
        check("R6 NRZ no err", err_o, 1'b0);
        check("R1 NRZ bit", bit_o, 1'b1);

        // R7: bit held between pulses
        @(negedge clk); line = 1'b0;
        @(negedge clk);
        check("R7 bit held", bit_o, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule